// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the bus-facing half of a 512-byte serial memory. It watches a two-wire bus that is sampled by the system clock. It finds START and STOP events, decodes the select byte against a fixed type code and two strap pins, and answers as a slave. An open-drain enable pulls the data line low to acknowledge or to send read data. The 512 bytes are split into two 256-byte blocks. One bit of the select byte chooses the block for a write, and a nine-bit internal counter tracks the current address for reads.

Writes are not stored directly. Each received data byte goes out on a byte port, together with the address it targets. A separate programming engine takes those bytes. When the write ends with STOP, the engine receives a commit pulse, raises a busy flag, and loads the bytes into the storage array through that array's own write port. While the busy flag is high the slave stays silent. A master finds out that programming has finished by sending select bytes until one is acknowledged. Reads come from the storage array, which this block holds. Every byte of that array reads FFh until it is written.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the SDA pull is released, no byte or commit pulse is issued, and every storage byte that has not been written since reset reads FFh.
- R2: The select byte is taken MSB first as bits [7:4] type code 1010, bit 3 compared with chip_en_hi_i, bit 2 compared with chip_en_lo_i, bit 1 block (address bit 8), bit 0 direction (1 = read). The slave pulls SDA low during the ninth clock only when the type code and both strap bits match. Otherwise it stays released and idles.
- R3: START (SDA falling while SCL high) begins a new select byte from any state, including in the middle of a byte. STOP (SDA rising while SCL high) returns to idle. Bits are taken on the SCL rising edge.
- R4: In a write, the slave acknowledges the byte address and every data byte. Each data byte appears for one cycle on the byte port, addressed as {block bit, counter}. After each byte only the low three address bits advance, wrapping inside the 8-byte row.
- R5: A STOP gives a one-cycle commit pulse only when at least one data byte was received since the last STOP. A write that holds only an address (the first half of a random read) gives no commit.
- R6: A read select byte returns the byte at the internal counter, and the counter then advances by one.
- R7: A random read, made of a write select, a byte address, a repeated START and a read select with the same upper seven bits, returns the byte at {block bit, byte address}.
- R8: While the master acknowledges, the slave keeps sending consecutive bytes. After address 1FFh the counter wraps to 000h.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next START.
- R10: While the busy input is high, START is ignored and no select byte is acknowledged. Once busy falls, a select byte is acknowledged again.
- R11: The SDA pull changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low (open drain) |
| chip_en_hi_i | input | 1 | Strap compared with select bit 3 |
| chip_en_lo_i | input | 1 | Strap compared with select bit 2 |
| store_we_i | input | 1 | Storage array write strobe from the programming engine |
| store_waddr_i | input | ADDR_W | Storage array write address |
| store_wdata_i | input | 8 | Storage array write data |
| prog_busy_i | input | 1 | Programming cycle in progress |
| prog_byte_vld_o | output | 1 | One-cycle strobe for a received data byte |
| prog_byte_addr_o | output | ADDR_W | Target address of that byte |
| prog_byte_data_o | output | 8 | Received data byte |
| prog_commit_o | output | 1 | One-cycle pulse: the write ended with STOP |

## Verification
The hardest state to reach from the ports is the silent window while programming runs. The bench's model of the programming engine raises busy for a fixed number of cycles after each commit. A select byte is sent at once to show it gets no answer, and the master then polls until an acknowledge comes back. The counter wrap from 1FFh to 000h is reached by a random read at the last byte followed by a sequential read with acknowledges. A START in the middle of an address byte is also forced, to show that the partial byte leaves the counter untouched.

// File: rtl/smem_pkg.sv
`timescale 1ns/1ps
package smem_pkg;
   localparam int BYTE_W = 8;
   localparam logic [3:0] SEL_TYPE_DEFAULT = 4'b1010;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SEL,
      ST_SELACK,
      ST_ADR,
      ST_ADRACK,
      ST_WDAT,
      ST_WDACK,
      ST_RDAT,
      ST_RDACK
   } phase_t;
endpackage

// File: rtl/smem_bus_sync.sv
`timescale 1ns/1ps
module smem_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl_o,
   output logic sda_lvl_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic              scl_q, sda_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe[0] <= 1'b1;
               sda_pipe[0] <= 1'b1;
            end else begin
               scl_pipe[0] <= scl_i;
               sda_pipe[0] <= sda_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe[s] <= 1'b1;
               sda_pipe[s] <= 1'b1;
            end else begin
               scl_pipe[s] <= scl_pipe[s-1];
               sda_pipe[s] <= sda_pipe[s-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_pipe[STAGES-1];
         sda_q <= sda_pipe[STAGES-1];
      end
   end

   assign scl_lvl_o  = scl_pipe[STAGES-1];
   assign sda_lvl_o  = sda_pipe[STAGES-1];
   assign scl_rise_o = scl_lvl_o & ~scl_q;
   assign scl_fall_o = ~scl_lvl_o & scl_q;
   assign start_o    = scl_lvl_o & scl_q & sda_q & ~sda_lvl_o;
   assign stop_o     = scl_lvl_o & scl_q & ~sda_q & sda_lvl_o;
endmodule

// File: rtl/smem_store.sv
`timescale 1ns/1ps
module smem_store #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] ERASED = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];
   logic [DEPTH-1:0]  written;

   always_ff @(posedge clk) begin
      if (we_i) cells[waddr_i] <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         written <= '0;
         rdata_o <= ERASED;
      end else begin
         if (we_i) written[waddr_i] <= 1'b1;
         rdata_o <= written[raddr_i] ? cells[raddr_i] : ERASED;
      end
   end
endmodule

// File: rtl/smem_proto.sv
`timescale 1ns/1ps
module smem_proto
   import smem_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int ROW_W  = 3,
   parameter logic [3:0] TYPE_CODE = SEL_TYPE_DEFAULT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              chip_en_hi,
   input  logic              chip_en_lo,
   input  logic              busy,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data,
   output logic              sda_pull,
   output logic              wb_vld,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [7:0]        wb_data,
   output logic              commit
);
   phase_t            state;
   logic [2:0]        bit_cnt;
   logic [6:0]        rx_sr;
   logic [6:0]        tx_sr;
   logic              seen;
   logic              sel_ok;
   logic              rw;
   logic              blk;
   logic              mack;
   logic              pend;
   logic [ADDR_W-1:0] addr_cnt;
   logic [7:0]        shift_in;
   logic              sel_hit_now;
   logic              in_ack;

   assign shift_in    = {rx_sr, sda_lvl};
   assign sel_hit_now = (shift_in[7:4] == TYPE_CODE) &&
                        (shift_in[3] == chip_en_hi) && (shift_in[2] == chip_en_lo);
   assign in_ack      = (state == ST_SELACK) || (state == ST_ADRACK) || (state == ST_WDACK);
   assign rd_addr     = addr_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         rx_sr    <= '0;
         tx_sr    <= '0;
         seen     <= 1'b0;
         sel_ok   <= 1'b0;
         rw       <= 1'b0;
         blk      <= 1'b0;
         mack     <= 1'b0;
         pend     <= 1'b0;
         addr_cnt <= '0;
         sda_pull <= 1'b0;
         wb_vld   <= 1'b0;
         wb_addr  <= '0;
         wb_data  <= '0;
         commit   <= 1'b0;
      end else begin
         wb_vld <= 1'b0;
         commit <= 1'b0;
         if (stop_det) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
            commit   <= pend;
            pend     <= 1'b0;
         end else if (start_det && !busy) begin
            state    <= ST_SEL;
            bit_cnt  <= '0;
            seen     <= 1'b0;
            sda_pull <= 1'b0;
         end else begin
            case (state)
               ST_SEL, ST_ADR, ST_WDAT: begin
                  if (scl_rise) begin
                     rx_sr   <= shift_in[6:0];
                     bit_cnt <= bit_cnt + 3'd1;
                     if (bit_cnt == 3'd7) begin
                        seen <= 1'b0;
                        if (state == ST_SEL) begin
                           state  <= ST_SELACK;
                           sel_ok <= sel_hit_now;
                           rw     <= shift_in[0];
                           blk    <= shift_in[1];
                        end else if (state == ST_ADR) begin
                           state    <= ST_ADRACK;
                           addr_cnt <= {blk, shift_in};
                        end else begin
                           state    <= ST_WDACK;
                           wb_vld   <= 1'b1;
                           wb_addr  <= addr_cnt;
                           wb_data  <= shift_in;
                           pend     <= 1'b1;
                           addr_cnt[ROW_W-1:0] <= addr_cnt[ROW_W-1:0] + ROW_W'(1);
                        end
                     end
                  end
               end
               ST_SELACK, ST_ADRACK, ST_WDACK: begin
                  if (scl_rise) begin
                     seen <= 1'b1;
                  end else if (scl_fall) begin
                     if (!seen) begin
                        if (state != ST_SELACK || sel_ok) sda_pull <= 1'b1;
                        else                              state    <= ST_IDLE;
                     end else begin
                        seen    <= 1'b0;
                        bit_cnt <= '0;
                        if (state == ST_SELACK && rw) begin
                           state    <= ST_RDAT;
                           tx_sr    <= rd_data[6:0];
                           sda_pull <= ~rd_data[7];
                        end else begin
                           sda_pull <= 1'b0;
                           state    <= (state == ST_SELACK) ? ST_ADR : ST_WDAT;
                        end
                     end
                  end
               end
               ST_RDAT: begin
                  if (scl_rise) begin
                     seen    <= 1'b1;
                     bit_cnt <= bit_cnt + 3'd1;
                  end else if (scl_fall && seen) begin
                     seen <= 1'b0;
                     if (bit_cnt == 3'd0) begin
                        state    <= ST_RDACK;
                        sda_pull <= 1'b0;
                        addr_cnt <= addr_cnt + ADDR_W'(1);
                     end else begin
                        tx_sr    <= {tx_sr[5:0], 1'b0};
                        sda_pull <= ~tx_sr[6];
                     end
                  end
               end
               ST_RDACK: begin
                  if (scl_rise) begin
                     seen <= 1'b1;
                     mack <= ~sda_lvl;
                  end else if (scl_fall && seen) begin
                     seen <= 1'b0;
                     if (mack) begin
                        state    <= ST_RDAT;
                        bit_cnt  <= '0;
                        tx_sr    <= rd_data[6:0];
                        sda_pull <= ~rd_data[7];
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R11
   sda_low_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> !scl_lvl);

   // R10
   busy_deaf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && state == ST_IDLE) |=> state == ST_IDLE);

   // R5
   commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> $past(stop_det));

   // R2
   sel_ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SELACK && sda_pull) |->
         (rx_sr[6:4] == TYPE_CODE[2:0] && rx_sr[3:2] == {chip_en_hi, chip_en_lo}));

   // R9
   nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_pull);

   logic unused_ok;
   assign unused_ok = in_ack;
endmodule

// File: rtl/serial_mem_slave.sv
`timescale 1ns/1ps
module serial_mem_slave
   import smem_pkg::*;
#(
   parameter int ADDR_W      = 9,
   parameter int ROW_W       = 3,
   parameter int SYNC_STAGES = 2,
   parameter logic [3:0] TYPE_CODE = SEL_TYPE_DEFAULT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   input  logic              chip_en_hi_i,
   input  logic              chip_en_lo_i,
   input  logic              store_we_i,
   input  logic [ADDR_W-1:0] store_waddr_i,
   input  logic [7:0]        store_wdata_i,
   input  logic              prog_busy_i,
   output logic              prog_byte_vld_o,
   output logic [ADDR_W-1:0] prog_byte_addr_o,
   output logic [7:0]        prog_byte_data_o,
   output logic              prog_commit_o
);
   if (ADDR_W != BYTE_W + 1) begin : g_bad_addr
      $error("ADDR_W must be one block bit above a byte address");
   end
   if (ROW_W < 1 || ROW_W >= BYTE_W) begin : g_bad_row
      $error("ROW_W must lie in 1..7");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic [ADDR_W-1:0] rd_addr;
   logic [7:0]        rd_data;

   smem_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_lvl_o  (scl_lvl),
      .sda_lvl_o  (sda_lvl),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_det),
      .stop_o     (stop_det)
   );

   smem_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (store_we_i),
      .waddr_i (store_waddr_i),
      .wdata_i (store_wdata_i),
      .raddr_i (rd_addr),
      .rdata_o (rd_data)
   );

   smem_proto #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .TYPE_CODE(TYPE_CODE)) i_proto (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_lvl    (scl_lvl),
      .sda_lvl    (sda_lvl),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .chip_en_hi (chip_en_hi_i),
      .chip_en_lo (chip_en_lo_i),
      .busy       (prog_busy_i),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .sda_pull   (sda_pull_o),
      .wb_vld     (prog_byte_vld_o),
      .wb_addr    (prog_byte_addr_o),
      .wb_data    (prog_byte_data_o),
      .commit     (prog_commit_o)
   );
endmodule

// File: tb/test_serial_mem_slave.sv
`timescale 1ns/1ps
module test_serial_mem_slave;
   localparam int BUSY_CYC = 1500;
   localparam int NVEC = 6;
   // {block, byte address, data}
   localparam logic [16:0] VEC [NVEC] = '{
      {1'b0, 8'h10, 8'h3C}, {1'b1, 8'h20, 8'hA5}, {1'b0, 8'hFF, 8'h5A},
      {1'b1, 8'hFF, 8'h81}, {1'b0, 8'h00, 8'h00}, {1'b1, 8'h07, 8'h7E}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic scl_m = 1'b1;
   logic sda_m_low = 1'b0;
   logic ce_hi = 1'b1, ce_lo = 1'b0;
   logic sda_pull;
   wire  sda_line = ~(sda_m_low | sda_pull);

   logic       st_we = 1'b0;
   logic [8:0] st_waddr = '0;
   logic [7:0] st_wdata = '0;
   logic       busy = 1'b0;
   logic       b_vld, b_commit;
   logic [8:0] b_addr;
   logic [7:0] b_data;

   serial_mem_slave i_serial_mem_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
      .chip_en_hi_i(ce_hi), .chip_en_lo_i(ce_lo),
      .store_we_i(st_we), .store_waddr_i(st_waddr), .store_wdata_i(st_wdata),
      .prog_busy_i(busy), .prog_byte_vld_o(b_vld), .prog_byte_addr_o(b_addr),
      .prog_byte_data_o(b_data), .prog_commit_o(b_commit)
   );

   int checks = 0, errors = 0;
   int n_log = 0, wptr = 0, commits = 0, bcnt = 0, viol = 0;
   logic [8:0] log_a [16];
   logic [7:0] log_d [16];
   logic prev_pull = 1'b0;

   // programming engine model and SDA-change monitor
   initial begin
      forever begin
         @(negedge clk);
         st_we = 1'b0;
         if (scl_m && sda_pull !== prev_pull) viol++;
         prev_pull = sda_pull;
         if (b_vld) begin
            log_a[n_log % 16] = b_addr;
            log_d[n_log % 16] = b_data;
            n_log++;
         end
         if (b_commit) begin
            commits++;
            busy = 1'b1;
            bcnt = BUSY_CYC;
         end else if (busy) begin
            if (wptr < n_log) begin
               st_we = 1'b1;
               st_waddr = log_a[wptr % 16];
               st_wdata = log_d[wptr % 16];
               wptr++;
            end
            bcnt--;
            if (bcnt == 0) busy = 1'b0;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic q();
      repeat (8) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m_low = 1'b0; q(); scl_m = 1'b1; q(); sda_m_low = 1'b1; q(); scl_m = 1'b0; q();
   endtask

   task automatic bus_stop();
      sda_m_low = 1'b1; q(); scl_m = 1'b1; q(); sda_m_low = 1'b0; q();
   endtask

   task automatic send_bit(input logic b);
      sda_m_low = ~b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
   endtask

   task automatic recv_bit(output logic b);
      sda_m_low = 1'b0; q(); scl_m = 1'b1; q(); b = sda_line; q(); scl_m = 1'b0; q();
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] d, input logic give_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         d[i] = b;
      end
      send_bit(~give_ack);
   endtask

   function automatic logic [7:0] sel(input logic blk, input logic rd);
      return {4'b1010, ce_hi, ce_lo, blk, rd};
   endfunction

   task automatic wait_ready();
      repeat (8) @(negedge clk);
      while (busy) @(negedge clk);
      q();
   endtask

   task automatic write_seq(input logic blk, input logic [7:0] adr, input int n,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
      logic a;
      logic [7:0] dv [3];
      dv[0] = d0; dv[1] = d1; dv[2] = d2;
      bus_start();
      send_byte(sel(blk, 1'b0), a); chk("R2 write select ack", a, 1);
      send_byte(adr, a);            chk("R4 byte address ack", a, 1);
      for (int i = 0; i < n; i++) begin
         send_byte(dv[i], a);       chk("R4 data ack", a, 1);
      end
      bus_stop();
   endtask

   task automatic rand_read(input logic blk, input logic [7:0] adr, output logic [7:0] d);
      logic a;
      bus_start();
      send_byte(sel(blk, 1'b0), a); chk("R7 dummy write select ack", a, 1);
      send_byte(adr, a);            chk("R7 dummy address ack", a, 1);
      bus_start();
      send_byte(sel(blk, 1'b1), a); chk("R7 read select ack", a, 1);
      recv_byte(d, 1'b0);
      bus_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic a, b;
      logic [7:0] d;
      int c0, nfail;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1 reset state
      chk("R1 sda released", sda_pull, 0);
      chk("R1 no byte strobe", b_vld, 0);
      chk("R1 no commit", b_commit, 0);

      // R6 / R1: current read right after reset returns erased byte
      bus_start();
      send_byte(sel(1'b0, 1'b1), a); chk("R6 current read ack", a, 1);
      recv_byte(d, 1'b0);            chk("R1 erased byte", d, 8'hFF);
      bus_stop();

      // R2 mismatches
      bus_start();
      send_byte({4'b1010, ~ce_hi, ce_lo, 1'b0, 1'b1}, a); chk("R2 strap mismatch no ack", a, 0);
      bus_stop();
      bus_start();
      send_byte({4'b1011, ce_hi, ce_lo, 1'b0, 1'b1}, a); chk("R2 type mismatch no ack", a, 0);
      bus_stop();
      ce_hi = 1'b0; ce_lo = 1'b1;
      bus_start();
      send_byte(sel(1'b0, 1'b1), a); chk("R2 new straps ack", a, 1);
      recv_byte(d, 1'b0);
      bus_stop();
      ce_hi = 1'b1; ce_lo = 1'b0;

      // table of write / random read vectors
      for (int v = 0; v < NVEC; v++) begin
         c0 = commits;
         write_seq(VEC[v][16], VEC[v][15:8], 1, VEC[v][7:0], 8'h00, 8'h00);
         repeat (6) @(negedge clk);
         chk("R5 commit after write stop", commits, c0 + 1);
         chk("R4 logged address", log_a[(n_log - 1) % 16], {VEC[v][16], VEC[v][15:8]});
         wait_ready();
         c0 = commits;
         rand_read(VEC[v][16], VEC[v][15:8], d);
         chk("R7 random read data", d, VEC[v][7:0]);
         repeat (6) @(negedge clk);
         chk("R5 no commit for dummy write", commits, c0);
      end

      // R4 row wrap of the low three bits
      write_seq(1'b0, 8'h46, 3, 8'h11, 8'h22, 8'h33);
      repeat (6) @(negedge clk);
      chk("R4 row byte 0 addr", log_a[(n_log - 3) % 16], 9'h046);
      chk("R4 row byte 1 addr", log_a[(n_log - 2) % 16], 9'h047);
      chk("R4 row wrap addr", log_a[(n_log - 1) % 16], 9'h040);
      wait_ready();
      rand_read(1'b0, 8'h40, d); chk("R4 wrapped byte stored", d, 8'h33);

      // R6 current read continues after a random read
      write_seq(1'b0, 8'h30, 3, 8'h99, 8'h77, 8'h55);
      wait_ready();
      rand_read(1'b0, 8'h30, d); chk("R7 row start", d, 8'h99);
      bus_start();
      send_byte(sel(1'b0, 1'b1), a); chk("R6 current read ack", a, 1);
      recv_byte(d, 1'b0);            chk("R6 current read data", d, 8'h77);
      bus_stop();

      // R3 START inside an address byte aborts it
      bus_start();
      send_byte(sel(1'b0, 1'b0), a); chk("R3 select ack", a, 1);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      bus_start();
      send_byte(sel(1'b0, 1'b1), a); chk("R3 restart select ack", a, 1);
      recv_byte(d, 1'b0);            chk("R3 counter untouched", d, 8'h55);
      bus_stop();

      // R10 busy: no answer, then polling
      write_seq(1'b1, 8'h50, 1, 8'h6D, 8'h00, 8'h00);
      bus_start();
      send_byte(sel(1'b1, 1'b0), a); chk("R10 no ack while busy", a, 0);
      bus_stop();
      nfail = 1;
      for (int k = 0; k < 40; k++) begin
         bus_start();
         send_byte(sel(1'b1, 1'b0), a);
         if (a) break;
         nfail++;
         bus_stop();
      end
      chk("R10 poll acked after busy", a, 1);
      chk("R10 busy seen by poll", (nfail > 1) ? 1 : 0, 1);
      bus_stop();
      rand_read(1'b1, 8'h50, d); chk("R10 byte written", d, 8'h6D);

      // R8 sequential read across 1FFh
      bus_start();
      send_byte(sel(1'b1, 1'b0), a);
      send_byte(8'hFF, a);
      bus_start();
      send_byte(sel(1'b1, 1'b1), a); chk("R8 read select ack", a, 1);
      recv_byte(d, 1'b1); chk("R8 byte at 1FFh", d, 8'h81);
      recv_byte(d, 1'b1); chk("R8 wrapped to 000h", d, 8'h00);
      recv_byte(d, 1'b0); chk("R8 byte at 001h", d, 8'hFF);
      // R9 after NACK nothing is driven
      c0 = 0;
      for (int i = 0; i < 9; i++) begin
         recv_bit(b);
         if (!b) c0++;
      end
      chk("R9 line released after nack", c0, 0);
      bus_stop();

      chk("R11 no SDA change while SCL high", viol, 0);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule